// File: doc/BRIEF.md
# Serial-command watchdog with coded timeout

This block supervises a host through the command words it receives. Every word has a 4-bit register address and 8 data bits. Bit 7 of the data is a keep-alive bit. The host flips that bit from one word to the next to show that it is alive. Each flip restarts the timeout count. If no flip arrives within the selected period, the block raises a sticky timeout flag toward the fail-safe logic.

A 2-bit select field picks the timeout period. The host writes it to the watchdog register, but the count only picks up the new value at the next restart. A running count therefore always completes with the period it started with.

A no-operation address lets words travel along a daisy chain without touching any setting, while still servicing the watchdog. A voltage-protection register holds two disable bits that mask the under-voltage and over-voltage fault flags. Words to every other address, including the direct-input and test addresses, change nothing here, but their keep-alive bit is still tracked.

Top module: `wdog_serial_ctl`

## Requirements
- R1: After reset, timeout_o is 0, act_sel_o is 00, and both protection-disable outputs are 0. The stored previous keep-alive bit is 0, and the count starts from reset with the period of code 00.
- R2: An accepted word whose bit 7 differs from bit 7 of the previous accepted word (a kick) restarts the count and clears timeout_o at the same clock edge.
- R3: An accepted word whose bit 7 equals that of the previous word neither restarts the count nor clears timeout_o.
- R4: The select code maps to a period in units: 00 gives 620, 01 gives 310, 10 gives 2500 and 11 gives 1250. One unit is PRESCALE clock cycles. timeout_o rises exactly period×PRESCALE clock edges after the restarting edge.
- R5: A word to address 4'b1101 stores data[1:0] as the pending select. act_sel_o takes the pending value only at a kick, and it takes the value from the same word when that word both writes and kicks. The period of a running count is never changed.
- R6: A word to address 4'b0110 (no-operation) changes no setting, but its kick still restarts the count.
- R7: A word to address 4'b1110 loads data[0] into uv_dis_o and data[1] into ov_dis_o. Both reset to 0, which leaves the protections enabled. uv_flag_o equals uv_fault_i AND NOT uv_dis_o, and ov_flag_o is formed the same way.
- R8: Words to the output-delay address 4'b0101, to the direct-input address x100, to the test address x111, and to any other address change neither the select nor the protection bits. Their kick still restarts the count.
- R9: Once set, timeout_o stays 1 and counting halts until the next kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | One-cycle strobe: a received word is present |
| word_addr_i | input | 4 | Register address of the word |
| word_data_i | input | 8 | Data bits; bit 7 is the keep-alive bit |
| uv_fault_i | input | 1 | Raw under-voltage fault |
| ov_fault_i | input | 1 | Raw over-voltage fault |
| timeout_o | output | 1 | Sticky watchdog expiry flag |
| act_sel_o | output | 2 | Select code of the running count |
| uv_dis_o | output | 1 | Under-voltage protection disabled |
| ov_dis_o | output | 1 | Over-voltage protection disabled |
| uv_flag_o | output | 1 | Masked under-voltage fault |
| ov_flag_o | output | 1 | Masked over-voltage fault |

## Verification
The bench builds the block with PRESCALE = 2. With that value all four coded periods, the longest being 5000 cycles, can be checked to the exact edge, and the prescaler branch of the timer is used instead of the bypass. Within those windows the bench also checks that a select write in the middle of a count does not change the running period, that a no-operation kick pushes the expiry back, and that the flag stays set once it has risen.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int KICK_BIT   = 7;
  localparam int MAX_PERIOD = 2500;

  localparam logic [ADDR_W-1:0] A_WDOG = 4'b1101;
  localparam logic [ADDR_W-1:0] A_NOP  = 4'b0110;
  localparam logic [ADDR_W-1:0] A_OSD  = 4'b0101;
  localparam logic [ADDR_W-1:0] A_PROT = 4'b1110;
  localparam logic [2:0]        A_DIN_LO  = 3'b100;
  localparam logic [2:0]        A_TEST_LO = 3'b111;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WDOG, CMD_NOP, CMD_OSD, CMD_PROT, CMD_DIN, CMD_TEST
  } cmd_e;

  // code order is not monotonic in period
  function automatic int unsigned period_units(logic [1:0] sel);
    case (sel)
      2'b00:   return 620;
      2'b01:   return 310;
      2'b10:   return 2500;
      default: return 1250;
    endcase
  endfunction
endpackage

// File: rtl/wdog_cmd_decode.sv
module wdog_cmd_decode
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              kick_bit_i,
  output cmd_e              cmd_o,
  output logic              kick_o
);
  logic prev_q;

  always_comb begin
    cmd_o = CMD_NONE;
    if      (addr_i == A_WDOG)      cmd_o = CMD_WDOG;
    else if (addr_i == A_NOP)       cmd_o = CMD_NOP;
    else if (addr_i == A_OSD)       cmd_o = CMD_OSD;
    else if (addr_i == A_PROT)      cmd_o = CMD_PROT;
    else if (addr_i[2:0] == A_DIN_LO)  cmd_o = CMD_DIN;
    else if (addr_i[2:0] == A_TEST_LO) cmd_o = CMD_TEST;
  end

  assign kick_o = valid_i && (kick_bit_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= 1'b0;
    else if (valid_i) prev_q <= kick_bit_i;
  end
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  cmd_e       cmd_i,
  input  logic       kick_i,
  input  logic [1:0] sel_bits_i,
  input  logic [1:0] prot_bits_i,
  output logic [1:0] act_sel_o,
  output logic       uv_dis_o,
  output logic       ov_dis_o
);
  logic [1:0] pend_q;
  logic       sel_wr;

  assign sel_wr = valid_i && (cmd_i == CMD_WDOG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 2'b00;
      act_sel_o <= 2'b00;
    end else begin
      if (sel_wr) pend_q <= sel_bits_i;
      // new period only at a restart; same-word write wins
      if (kick_i) act_sel_o <= sel_wr ? sel_bits_i : pend_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_dis_o <= 1'b0;
      ov_dis_o <= 1'b0;
    end else if (valid_i && cmd_i == CMD_PROT) begin
      uv_dis_o <= prot_bits_i[0];
      ov_dis_o <= prot_bits_i[1];
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRESCALE = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       timeout_o
);
  localparam int UNIT_W = $clog2(MAX_PERIOD);

  logic              unit_tick;
  logic [UNIT_W-1:0] unit_q;
  logic [UNIT_W-1:0] limit;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRESCALE);
      logic [PRE_W-1:0] pre_q;
      logic             pre_last;
      assign pre_last  = (pre_q == PRE_W'(PRESCALE - 1));
      assign unit_tick = pre_last && !timeout_o;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     pre_q <= '0;
        else if (restart_i || timeout_o) pre_q <= '0;
        else if (pre_last)               pre_q <= '0;
        else                             pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign unit_tick = !timeout_o;
    end
  endgenerate

  assign limit = UNIT_W'(period_units(sel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q    <= '0;
      timeout_o <= 1'b0;
    end else if (restart_i) begin
      unit_q    <= '0;
      timeout_o <= 1'b0;
    end else if (unit_tick) begin
      if (unit_q == limit) begin
        unit_q    <= '0;
        timeout_o <= 1'b1;
      end else begin
        unit_q <= unit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_serial_ctl.sv
module wdog_serial_ctl
  import wdog_pkg::*;
#(
  parameter int PRESCALE = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       word_valid_i,
  input  logic [3:0] word_addr_i,
  input  logic [7:0] word_data_i,
  input  logic       uv_fault_i,
  input  logic       ov_fault_i,
  output logic       timeout_o,
  output logic [1:0] act_sel_o,
  output logic       uv_dis_o,
  output logic       ov_dis_o,
  output logic       uv_flag_o,
  output logic       ov_flag_o
);
  cmd_e cmd;
  logic kick;
  logic unused_data;

  assign unused_data = ^word_data_i[6:2];

  wdog_cmd_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (word_valid_i),
    .addr_i     (word_addr_i),
    .kick_bit_i (word_data_i[KICK_BIT]),
    .cmd_o      (cmd),
    .kick_o     (kick)
  );

  wdog_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (word_valid_i),
    .cmd_i       (cmd),
    .kick_i      (kick),
    .sel_bits_i  (word_data_i[1:0]),
    .prot_bits_i (word_data_i[1:0]),
    .act_sel_o   (act_sel_o),
    .uv_dis_o    (uv_dis_o),
    .ov_dis_o    (ov_dis_o)
  );

  wdog_timer #(.PRESCALE(PRESCALE)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (kick),
    .sel_i     (act_sel_o),
    .timeout_o (timeout_o)
  );

  assign uv_flag_o = uv_fault_i && !uv_dis_o;
  assign ov_flag_o = ov_fault_i && !ov_dis_o;
endmodule

// File: rtl/wdog_serial_ctl_chk.sv
module wdog_serial_ctl_chk #(
  parameter int PRESCALE = 50000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       word_valid_i,
  input logic [3:0] word_addr_i,
  input logic [7:0] word_data_i,
  input logic       timeout_o,
  input logic [1:0] act_sel_o,
  input logic       uv_dis_o,
  input logic       ov_dis_o
);
  logic        chk_d7;
  logic        chk_kick;
  int unsigned elapsed;

  assign chk_kick = word_valid_i && (word_data_i[7] != chk_d7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_d7  <= 1'b0;
      elapsed <= 0;
    end else begin
      if (word_valid_i) chk_d7 <= word_data_i[7];
      if (chk_kick)                   elapsed <= 0;
      else if (elapsed != 32'hFFFF_FFFF) elapsed <= elapsed + 1;
    end
  end

  a_r2_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_kick |=> !timeout_o);

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !chk_kick) |=> timeout_o);

  a_r5_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_kick |=> $stable(act_sel_o));

  a_r7_prot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i && word_addr_i == 4'b1110) |=> $stable({uv_dis_o, ov_dis_o}));

  a_r4_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (elapsed == wdog_pkg::period_units(act_sel_o) * PRESCALE));
endmodule

bind wdog_serial_ctl wdog_serial_ctl_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .word_addr_i  (word_addr_i),
  .word_data_i  (word_data_i),
  .timeout_o    (timeout_o),
  .act_sel_o    (act_sel_o),
  .uv_dis_o     (uv_dis_o),
  .ov_dis_o     (ov_dis_o)
);

// File: tb/tb_wdog_serial_ctl.sv
`timescale 1ns/1ps
module tb_wdog_serial_ctl;
  localparam int PRESCALE = 2;
  localparam int NVEC = 10;
  // {addr[3:0], data[7:0], exp_sel[1:0], exp_uv_dis, exp_ov_dis}
  localparam logic [15:0] VEC [NVEC] = '{
    16'hD010, 16'h6804, 16'hE816, 16'hE025, 16'hD829,
    16'h5839, 16'hC039, 16'h7819, 16'h6039, 16'hE808
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  logic       uv_f = 1'b1;
  logic       ov_f = 1'b1;
  logic       timeout;
  logic [1:0] act_sel;
  logic       uv_dis, ov_dis, uv_flag, ov_flag;
  logic       tb_d7 = 1'b0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdog_serial_ctl #(.PRESCALE(PRESCALE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(valid), .word_addr_i(addr),
    .word_data_i(data), .uv_fault_i(uv_f), .ov_fault_i(ov_f),
    .timeout_o(timeout), .act_sel_o(act_sel), .uv_dis_o(uv_dis),
    .ov_dis_o(ov_dis), .uv_flag_o(uv_flag), .ov_flag_o(ov_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; consumes exactly one posedge
  task automatic send(input logic [3:0] a, input logic [7:0] d);
    valid = 1'b1; addr = a; data = d;
    @(negedge clk);
    valid = 1'b0;
    tb_d7 = d[7];
  endtask

  task automatic kick(input logic [3:0] a, input logic [6:0] low);
    send(a, {~tb_d7, low});
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expiry(input string req, input int units);
    wait_edges(units * PRESCALE - 1);
    chk({req, " before expiry"}, {31'b0, timeout}, 0);
    wait_edges(1);
    chk({req, " at expiry"}, {31'b0, timeout}, 1);
  endtask

  initial begin
    wait_edges(3000000 / 20 * 2 / 3);
  end

  initial begin
    #(4000000.0);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);
    // R1 reset state
    chk("R1 timeout", {31'b0, timeout}, 0);
    chk("R1 sel", {30'b0, act_sel}, 0);
    chk("R1 dis", {30'b0, uv_dis, ov_dis}, 0);
    chk("R7 flags after reset", {30'b0, uv_flag, ov_flag}, 2'b11);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][15:12], VEC[i][11:4]);
      chk($sformatf("R5/R6/R8 sel vec%0d", i), {30'b0, act_sel}, {30'b0, VEC[i][3:2]});
      chk($sformatf("R7/R8 uv vec%0d", i), {31'b0, uv_dis}, {31'b0, VEC[i][1]});
      chk($sformatf("R7/R8 ov vec%0d", i), {31'b0, ov_dis}, {31'b0, VEC[i][0]});
      chk($sformatf("R7 flags vec%0d", i), {30'b0, uv_flag, ov_flag},
          {30'b0, ~VEC[i][1], ~VEC[i][0]});
    end

    // R4 code 01 -> 310 units
    kick(4'hD, 7'h01);
    chk("R5 same-word sel", {30'b0, act_sel}, 1);
    expiry("R4 code01", 310);
    // R9 sticky, R3 no clear on same bit
    wait_edges(50);
    chk("R9 sticky", {31'b0, timeout}, 1);
    send(4'h6, {tb_d7, 7'h0});
    chk("R3 same bit keeps flag", {31'b0, timeout}, 1);
    kick(4'h6, 7'h0);
    chk("R2 kick clears", {31'b0, timeout}, 0);

    // R4 code 00
    kick(4'hD, 7'h00);
    expiry("R4 code00", 620);
    // R4 code 11
    kick(4'hD, 7'h03);
    expiry("R4 code11", 1250);
    // R4 code 10
    kick(4'hD, 7'h02);
    expiry("R4 code10", 2500);

    // R5 mid-count write does not alter running period
    kick(4'hD, 7'h03);
    wait_edges(100);
    send(4'hD, {tb_d7, 7'h00});
    chk("R5 sel held mid-count", {30'b0, act_sel}, 3);
    wait_edges(1250 * PRESCALE - 101 - 1);
    chk("R5 before expiry", {31'b0, timeout}, 0);
    wait_edges(1);
    chk("R5 at expiry", {31'b0, timeout}, 1);

    // R6 no-op kick applies pending code and restarts
    kick(4'h6, 7'h03);
    chk("R6 pending applied", {30'b0, act_sel}, 0);
    wait_edges(600);
    kick(4'h6, 7'h03);
    chk("R6 sel unchanged", {30'b0, act_sel}, 0);
    expiry("R6 restart", 620);

    // R8 test-address kick restarts count
    kick(4'hF, 7'h03);
    chk("R8 test addr clears", {31'b0, timeout}, 0);
    chk("R8 test addr sel", {30'b0, act_sel}, 0);
    expiry("R8 restart", 620);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule